// File: doc/BRIEF.md
# Dual AND-Tree Barrier Synchronizer

This block synchronizes a set of N processors at barrier points. Each processor pulses its arrive input when it reaches a barrier. It then waits until its release output goes high, which happens only after every participating processor has arrived. Two separate AND trees gather the arrival flags. Each processor carries a phase bit that picks the tree its next arrival marks, and the bit flips each time that processor is released. Successive barriers therefore always use different trees.

With a single tree, a fast processor could leave the barrier and lower its flag for the next episode before a slower processor had looked at the result. The slow processor would then miss completion and wait forever. Here a flag on one tree stays up until its owner arrives on the other tree, and release is held until the owner's next arrival. A late observer therefore still sees the completed episode.

A participant mask takes idle processors out of the set. A masked processor counts as arrived in both trees.

Top module: `dual_tree_barrier`

## Requirements
- R1: During and right after reset every release output is 0 and every phase output is 0.
- R2: A processor's release never rises before every participating processor has arrived at that barrier.
- R3: Release rises on the rising edge right after the edge that samples the last participant's arrive pulse.
- R4: A processor's phase bit flips exactly when its release rises. Phase 0 marks the first tree and phase 1 the second, so consecutive barriers use different trees.
- R5: Release stays high until the same processor's next accepted arrive pulse, and drops on the edge that samples that pulse.
- R6: An arrive pulse while the processor is waiting (arrived and not yet released) has no effect: release stays 0 and the phase does not change.
- R7: When a fast processor re-arrives for the next barrier, the release of a slower processor that has not yet re-arrived stays high.
- R8: A processor whose mask bit is 0 counts as arrived in both trees. The remaining participants are released without it.
- R9: Under random per-processor delays between arrival, release sampling and re-arrival, every barrier completes with no deadlock and no early release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive | input | N | One-cycle arrival pulse per processor |
| part_mask | input | N | 1 = processor takes part in barriers |
| release_o | output | N | Per-processor release, held until the next arrival |
| phase_o | output | N | Per-processor tree selector for the next arrival |

## Verification
The bench aims at the race this block exists to prevent. A fast processor re-arrives while others still hold their release. A design that cleared flags on the shared tree, or that gave release only as a pulse, would drop the slow processors' release, and the random phase would then deadlock or trip the watchdog. The bench also fires a duplicate arrival during a wait. A design that accepted it would toggle the phase twice or release early. Exact-cycle latency checks catch an extra or a missing register stage. The per-round ordering check catches a release that fires while any participant's arrival count is still behind. The masked-processor case catches a design that waits on an idle processor forever.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

  // Flags an arrival raises: the tree picked by phase goes high, the other clears.
  function automatic logic [1:0] arrival_flags(input logic phase);
    return phase ? 2'b10 : 2'b01;
  endfunction

  // A processor outside the participant set reads as permanently arrived.
  function automatic logic tree_leaf(input logic flag, input logic member);
    return flag | ~member;
  endfunction

  // Number of reduction levels for an n-input tree.
  function automatic int tree_levels(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

endpackage

// File: rtl/dtb_and_tree.sv
module dtb_and_tree
  import dtb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] leaf,
  output logic         all_set
);
  localparam int LV = tree_levels(N);
  localparam int W  = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    logic [(W>>l)-1:0] v;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_pad
        if (j < N) begin : g_real
          assign v[j] = leaf[j];
        end else begin : g_fill
          assign v[j] = 1'b1;
        end
      end
    end else begin : g_red
      for (genvar j = 0; j < (W >> l); j++) begin : g_node
        assign v[j] = g_lvl[l-1].v[2*j] & g_lvl[l-1].v[2*j+1];
      end
    end
  end

  assign all_set = g_lvl[LV].v[0];
endmodule

// File: rtl/dtb_port.sv
module dtb_port
  import dtb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arrive,
  input  logic [1:0] tree_full,
  output logic [1:0] flag_o,
  output logic       release_o,
  output logic       phase_o,
  output logic       accept_o,
  output logic       fire_o
);
  logic busy_q;

  // Arrival counts only when not already waiting (R6).
  assign accept_o = arrive & ~busy_q;
  // Completion of the tree this processor waits on.
  assign fire_o   = busy_q & tree_full[phase_o];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      release_o <= 1'b0;
      phase_o   <= 1'b0;
      flag_o    <= 2'b00;
    end else if (accept_o) begin
      busy_q    <= 1'b1;
      release_o <= 1'b0;                  // R5: drops at own next arrival
      flag_o    <= arrival_flags(phase_o);
    end else if (fire_o) begin
      busy_q    <= 1'b0;
      release_o <= 1'b1;                  // R3: registered completion
      phase_o   <= ~phase_o;              // R4
    end
  end
endmodule

// File: rtl/dual_tree_barrier.sv
module dual_tree_barrier
  import dtb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrive,
  input  logic [N-1:0] part_mask,
  output logic [N-1:0] release_o,
  output logic [N-1:0] phase_o
);
  logic [N-1:0] leaf_a;
  logic [N-1:0] leaf_b;
  logic [N-1:0] accept;
  logic [N-1:0] fire;
  logic [1:0]   tree_full;

  for (genvar i = 0; i < N; i++) begin : g_proc
    logic [1:0] fl;
    dtb_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive    (arrive[i]),
      .tree_full (tree_full),
      .flag_o    (fl),
      .release_o (release_o[i]),
      .phase_o   (phase_o[i]),
      .accept_o  (accept[i]),
      .fire_o    (fire[i])
    );
    assign leaf_a[i] = tree_leaf(fl[0], part_mask[i]);  // R8
    assign leaf_b[i] = tree_leaf(fl[1], part_mask[i]);
  end

  dtb_and_tree #(.N(N)) u_tree_a (.leaf(leaf_a), .all_set(tree_full[0]));
  dtb_and_tree #(.N(N)) u_tree_b (.leaf(leaf_b), .all_set(tree_full[1]));
endmodule

// File: rtl/dtb_checker.sv
module dtb_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] arrive,
  input logic [N-1:0] part_mask,
  input logic [N-1:0] release_o,
  input logic [N-1:0] phase_o,
  input logic [1:0]   tree_full,
  input logic [N-1:0] accept,
  input logic [N-1:0] fire
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    p_rel_from_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(release_o[i]) && phase_o[i]) |-> $past(tree_full[0]));
    p_rel_from_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(release_o[i]) && !phase_o[i]) |-> $past(tree_full[1]));
    p_fire_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> release_o[i]);
    p_phase_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(phase_o[i]) |-> $rose(release_o[i]));
    p_rel_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(release_o[i]) |-> $past(arrive[i]));
    p_ignore_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (arrive[i] && !accept[i] && !fire[i]) |=> ($stable(phase_o[i]) && !release_o[i]));
  end

  p_one_tree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|part_mask) |-> !(tree_full[0] && tree_full[1]));
endmodule

bind dual_tree_barrier dtb_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arrive    (arrive),
  .part_mask (part_mask),
  .release_o (release_o),
  .phase_o   (phase_o),
  .tree_full (tree_full),
  .accept    (accept),
  .fire      (fire)
);

// File: tb/dual_tree_barrier_bench.sv
`timescale 1ns/1ps
module dual_tree_barrier_bench;
  localparam int N = 8;
  localparam int ROUNDS = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] arrive;
  logic [N-1:0] part_mask;
  logic [N-1:0] release_o;
  logic [N-1:0] phase_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int arr_cnt [N];

  always #4 clk = ~clk;

  dual_tree_barrier #(.N(N)) u_dual_tree_barrier (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .part_mask(part_mask),
    .release_o(release_o), .phase_o(phase_o)
  );

  function automatic logic exp_phase(input int k);
    return k[0];
  endfunction

  function automatic bit all_reached(input int k);
    for (int j = 0; j < N; j++) if (arr_cnt[j] < k) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic proc_run(input int q);
    for (int k = 1; k <= ROUNDS; k++) begin
      repeat ($urandom_range(0, 6)) @(negedge clk);
      arrive[q] = 1'b1;
      arr_cnt[q] = k;
      @(negedge clk);
      arrive[q] = 1'b0;
      while (release_o[q] !== 1'b1) @(negedge clk);
      repeat ($urandom_range(0, 5)) @(negedge clk);
      // R9 / R2: nobody passes barrier k before all have arrived at it
      chk(all_reached(k), "R9 order", 32'(k), 32'(k));
      chk(phase_o[q] == exp_phase(k), "R4 phase", 32'(phase_o[q]), 32'(exp_phase(k)));
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    rst_n = 1'b0; arrive = '0; part_mask = '1;
    for (int j = 0; j < N; j++) arr_cnt[j] = 0;
    repeat (3) @(negedge clk);
    chk(release_o == '0, "R1 release", 32'(release_o), 0);
    chk(phase_o == '0, "R1 phase", 32'(phase_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(release_o == '0 && phase_o == '0, "R1 after", 32'({release_o, phase_o}), 0);

    // Barrier 1: everyone at once; latency check
    arrive = '1;
    @(negedge clk); arrive = '0;
    chk(release_o == '0, "R3 not yet", 32'(release_o), 0);
    @(negedge clk);
    chk(release_o == '1, "R3 release", 32'(release_o), 32'hFF);
    chk(phase_o == '1, "R4 toggle", 32'(phase_o), 32'hFF);

    // Barrier 2: fast proc 0 re-arrives while others still hold release
    arrive[0] = 1'b1;
    @(negedge clk); arrive = '0;
    chk(release_o[0] == 1'b0, "R5 drop", 32'(release_o[0]), 0);
    chk(release_o[N-1:1] == '1, "R7 slow keeps", 32'(release_o), 32'hFE);
    arrive[0] = 1'b1;                       // duplicate while waiting
    @(negedge clk); arrive = '0;
    @(negedge clk);
    chk(release_o[0] == 1'b0 && phase_o[0] == 1'b1, "R6 ignored",
        32'({release_o[0], phase_o[0]}), 32'h1);
    chk(release_o[N-1:1] == '1, "R7 still held", 32'(release_o), 32'hFE);
    arrive = 8'hFE;
    @(negedge clk); arrive = '0;
    chk(release_o == '0, "R2 none early", 32'(release_o), 0);
    @(negedge clk);
    chk(release_o == '1, "R3 barrier2", 32'(release_o), 32'hFF);
    chk(phase_o == '0, "R4 alternate", 32'(phase_o), 0);

    // Random phase: independent processors with random delays
    for (int p = 0; p < N; p++) begin
      automatic int q = p;
      fork proc_run(q); join_none
    end
    wait fork;

    // Mask: processor 7 idle, others still complete
    @(negedge clk);
    part_mask = 8'h7F;
    arrive = 8'h7F;
    @(negedge clk); arrive = '0;
    chk(release_o[6:0] == '0, "R8 not yet", 32'(release_o), 0);
    @(negedge clk);
    chk(release_o[6:0] == 7'h7F, "R8 masked release", 32'(release_o[6:0]), 32'h7F);
    chk(phase_o[6:0] == 7'h7F, "R8 phase", 32'(phase_o[6:0]), 32'h7F);

    total++;                                // R9: reached end without deadlock
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 deadlock actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule